// File: doc/BRIEF.md
# Burst-of-two quad-data-rate SRAM core

This block is a storage core with two fully independent ports, one for reads and one for writes, that share a single word array. Each port has an active-low select sampled on the rising edge of the reference clock `clk`. Every accepted transaction moves a burst of two words. The two double-data-rate beats are carried as two parallel word lanes within one `clk` cycle: beat 0 and beat 1.

For a burst address A, beat 0 addresses word A and beat 1 addresses word A with bit 0 forced to 1. A burst therefore stays inside one aligned word pair. An accepted write is parked in a pending stage for one cycle and then committed to the array. Reads check both the write being accepted on the same edge and the pending write before they fall back to the array, so a read always sees the newest data.

There is no back-pressure at either edge. The write port accepts a burst on every selected edge. The read port has no ready input: each accepted read presents its two beats, qualified by `rd_valid`, for exactly the cycle after acceptance, and the consumer must take them in that cycle.

Top module: `qdr_b2_sram`

## Requirements
- R1: While `rst_n` is low and in the first cycle after release, `rd_valid` is 0 and both read lanes are 0, whatever the selects are. No write accepted during reset reaches the array.
- R2: When `wr_sel_n` is 0 at a rising edge, the write is accepted. `wr_beat0` is stored at word `wr_addr`, and `wr_beat1` is stored at word `wr_addr` with bit 0 set to 1.
- R3: When `rd_sel_n` is 0 at a rising edge, in the following cycle `rd_valid` is 1, `rd_beat0` holds word `rd_addr` and `rd_beat1` holds word `rd_addr` with bit 0 set to 1. In a cycle after an edge with `rd_sel_n` high, `rd_valid` is 0 and both lanes are 0.
- R4: For an odd burst address both beats name the same word. A write then leaves beat 1's data in that word, and a read returns that word on both lanes.
- R5: A read accepted on the edge after a write to the same words returns the written data and not the older array contents.
- R6: A read and a write accepted on the same edge to the same words return the data of that write. When both the current write and the previous write hit a word, the current write wins.
- R7: When `wr_sel_n` is 1 at an edge, the write lanes and `wr_addr` are ignored and no array word changes.
- R8: The ports are independent. A read and a write to different addresses on the same edge both complete. Deselecting one port does not disturb the other. A write or read that was already accepted completes even if its port is deselected on the next edge.
- R9: Reads accepted on consecutive edges give consecutive valid cycles, each holding the data of its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all sampling on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_sel_n | input | 1 | Active-low write select |
| wr_addr | input | ADDR_W | Write burst word address |
| wr_beat0 | input | DATA_W | Write data for the first burst word |
| wr_beat1 | input | DATA_W | Write data for the second burst word |
| rd_sel_n | input | 1 | Active-low read select |
| rd_addr | input | ADDR_W | Read burst word address |
| rd_valid | output | 1 | Read lanes hold burst data this cycle |
| rd_beat0 | output | DATA_W | Read data for the first burst word |
| rd_beat1 | output | DATA_W | Read data for the second burst word |

## Verification
The array is first filled with even-aligned bursts and read back. This separates correct lane-to-word mapping from swapped or shifted lanes. Odd burst addresses show whether beat 1 wins inside a shared word and whether a read duplicates that word. Reads placed zero, one and two edges after a write to the same pair tell the same-edge path, the pending-forward path and the committed-array path apart; a stacked pair of writes checks their priority. Deselected writes carrying junk, overlapping traffic on both ports, and an unbroken run of reads show whether each port ignores or completes work independently of the other.

// File: rtl/qdr_b2_pkg.sv
package qdr_b2_pkg;
  // Number of words moved by one accepted transaction.
  localparam int BEATS = 2;
  // Address bit that selects a word inside an aligned pair.
  localparam int PAIR_BIT = 0;
endpackage

// File: rtl/qdr_b2_wr_stage.sv
module qdr_b2_wr_stage
  import qdr_b2_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           live_vld,
  input  logic [BEATS-1:0][ADDR_W-1:0]   live_word,
  input  logic [BEATS-1:0][DATA_W-1:0]   live_data,
  output logic                           pend_vld,
  output logic [BEATS-1:0][ADDR_W-1:0]   pend_word,
  output logic [BEATS-1:0][DATA_W-1:0]   pend_data
);

  // One-cycle holding stage between write acceptance and array commit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_word <= '0;
      pend_data <= '0;
    end else begin
      pend_vld <= live_vld;
      if (live_vld) begin
        pend_word <= live_word;
        pend_data <= live_data;
      end
    end
  end

  AST_WR_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    live_vld |=> pend_vld); // R2
  AST_WR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    live_vld |=> (pend_data == $past(live_data) && pend_word == $past(live_word))); // R2
  AST_WR_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    !live_vld |=> !pend_vld); // R7

endmodule

// File: rtl/qdr_b2_array.sv
module qdr_b2_array
  import qdr_b2_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic                           clk,
  input  logic                           we,
  input  logic [BEATS-1:0][ADDR_W-1:0]   wword,
  input  logic [BEATS-1:0][DATA_W-1:0]   wdata,
  input  logic [BEATS-1:0][ADDR_W-1:0]   rword,
  output logic [BEATS-1:0][DATA_W-1:0]   rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Lanes are written in ascending order so the later beat wins a shared word.
  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < BEATS; b++) begin
        mem[wword[b]] <= wdata[b];
      end
    end
  end

  for (genvar b = 0; b < BEATS; b++) begin : g_rd
    assign rdata[b] = mem[rword[b]];
  end

endmodule

// File: rtl/qdr_b2_rd_stage.sv
module qdr_b2_rd_stage
  import qdr_b2_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_sel_n,
  input  logic [ADDR_W-1:0]              rd_addr,
  input  logic                           live_vld,
  input  logic [BEATS-1:0][ADDR_W-1:0]   live_word,
  input  logic [BEATS-1:0][DATA_W-1:0]   live_data,
  input  logic                           pend_vld,
  input  logic [BEATS-1:0][ADDR_W-1:0]   pend_word,
  input  logic [BEATS-1:0][DATA_W-1:0]   pend_data,
  output logic [BEATS-1:0][ADDR_W-1:0]   arr_word,
  input  logic [BEATS-1:0][DATA_W-1:0]   arr_data,
  output logic                           rd_valid,
  output logic [BEATS-1:0][DATA_W-1:0]   rd_data
);

  logic [BEATS-1:0][DATA_W-1:0] pick;

  for (genvar b = 0; b < BEATS; b++) begin : g_word
    if (b == 0) begin : g_base
      assign arr_word[b] = rd_addr;
    end else begin : g_odd
      assign arr_word[b] = rd_addr | ADDR_W'(1 << PAIR_BIT);
    end
  end

  // Per-word newest-data selection: array, then pending write, then the
  // write accepted on this edge; within a burst the later beat wins.
  always_comb begin
    for (int b = 0; b < BEATS; b++) begin
      pick[b] = arr_data[b];
      if (pend_vld) begin
        for (int w = 0; w < BEATS; w++) begin
          if (pend_word[w] == arr_word[b]) pick[b] = pend_data[w];
        end
      end
      if (live_vld) begin
        for (int w = 0; w < BEATS; w++) begin
          if (live_word[w] == arr_word[b]) pick[b] = live_data[w];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= !rd_sel_n;
      rd_data  <= rd_sel_n ? '0 : pick;
    end
  end

  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel_n |=> rd_valid); // R3
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel_n |=> (!rd_valid && rd_data == '0)); // R3
  AST_ODD_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_sel_n && rd_addr[PAIR_BIT]) |=> (rd_data[0] == rd_data[1])); // R4
  AST_PEND_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_sel_n && pend_vld && !live_vld && !rd_addr[PAIR_BIT]
     && pend_word[0] == rd_addr) |=> (rd_data == $past(pend_data))); // R5

endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram
  import qdr_b2_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_beat0,
  input  logic [DATA_W-1:0] wr_beat1,
  input  logic              rd_sel_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_beat0,
  output logic [DATA_W-1:0] rd_beat1
);

  logic                         live_vld;
  logic [BEATS-1:0][ADDR_W-1:0] live_word;
  logic [BEATS-1:0][DATA_W-1:0] live_data;
  logic                         pend_vld;
  logic [BEATS-1:0][ADDR_W-1:0] pend_word;
  logic [BEATS-1:0][DATA_W-1:0] pend_data;
  logic [BEATS-1:0][ADDR_W-1:0] arr_word;
  logic [BEATS-1:0][DATA_W-1:0] arr_data;
  logic [BEATS-1:0][DATA_W-1:0] rd_data;

  assign live_vld  = !wr_sel_n;
  assign live_data = {wr_beat1, wr_beat0};

  for (genvar b = 0; b < BEATS; b++) begin : g_wword
    if (b == 0) begin : g_base
      assign live_word[b] = wr_addr;
    end else begin : g_odd
      assign live_word[b] = wr_addr | ADDR_W'(1 << PAIR_BIT);
    end
  end

  qdr_b2_wr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .live_vld  (live_vld),
    .live_word (live_word),
    .live_data (live_data),
    .pend_vld  (pend_vld),
    .pend_word (pend_word),
    .pend_data (pend_data)
  );

  qdr_b2_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk   (clk),
    .we    (pend_vld),
    .wword (pend_word),
    .wdata (pend_data),
    .rword (arr_word),
    .rdata (arr_data)
  );

  qdr_b2_rd_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_sel_n  (rd_sel_n),
    .rd_addr   (rd_addr),
    .live_vld  (live_vld),
    .live_word (live_word),
    .live_data (live_data),
    .pend_vld  (pend_vld),
    .pend_word (pend_word),
    .pend_data (pend_data),
    .arr_word  (arr_word),
    .arr_data  (arr_data),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  assign rd_beat0 = rd_data[0];
  assign rd_beat1 = rd_data[1];

  AST_SAME_EDGE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_sel_n && !wr_sel_n && rd_addr == wr_addr && !wr_addr[PAIR_BIT])
    |=> (rd_beat0 == $past(wr_beat0) && rd_beat1 == $past(wr_beat1))); // R6
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!rd_valid && rd_beat0 == '0 && rd_beat1 == '0)); // R1

endmodule

// File: tb/qdr_b2_sram_tb.sv
`timescale 1ns/1ps
module qdr_b2_sram_tb;
  localparam int AW = 6;
  localparam int DW = 18;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_sel_n = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_beat0 = '0;
  logic [DW-1:0] wr_beat1 = '0;
  logic          rd_sel_n = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_beat0;
  logic [DW-1:0] rd_beat1;

  logic [DW-1:0] ref_mem [DEPTH];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  qdr_b2_sram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_sel_n(wr_sel_n), .wr_addr(wr_addr), .wr_beat0(wr_beat0), .wr_beat1(wr_beat1),
    .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_beat0(rd_beat0), .rd_beat1(rd_beat1)
  );

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'(a * 613 + k * 4099 + 17);
  endfunction

  task automatic check(input string tag, input logic v, input logic [DW-1:0] b0,
                       input logic [DW-1:0] b1);
    n_checks++;
    if (rd_valid !== v || rd_beat0 !== b0 || rd_beat1 !== b1) begin
      n_fail++;
      $display("FAIL %s: got v=%0b b0=%h b1=%h expected v=%0b b0=%h b1=%h",
               tag, rd_valid, rd_beat0, rd_beat1, v, b0, b1);
    end
  endtask

  // One clock cycle: drive at the falling edge, check after the next falling edge.
  task automatic step(input logic rs_n, input int ra, input logic ws_n, input int wa,
                      input logic [DW-1:0] d0, input logic [DW-1:0] d1, input string tag);
    logic          ev;
    logic [DW-1:0] e0, e1;
    rd_sel_n = rs_n; rd_addr = AW'(ra);
    wr_sel_n = ws_n; wr_addr = AW'(wa); wr_beat0 = d0; wr_beat1 = d1;
    if (!ws_n) begin
      ref_mem[wa] = d0;
      ref_mem[wa | 1] = d1;
    end
    ev = !rs_n;
    e0 = ev ? ref_mem[ra] : '0;
    e1 = ev ? ref_mem[ra | 1] : '0;
    @(posedge clk);
    @(negedge clk);
    check(tag, ev, e0, e1);
  endtask

  task automatic idle(input string tag);
    step(1'b1, 0, 1'b1, 0, pat(99, 9), pat(98, 8), tag);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, '0, '0);
    rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    rst_n = 1'b1;
    idle("R1 after release");
  endtask

  task automatic t_fill();
    for (int a = 0; a < DEPTH; a += 2) step(1'b1, 0, 1'b0, a, pat(a, 0), pat(a, 1), "R2 fill");
    idle("R2 settle");
    for (int a = 0; a < DEPTH; a += 2) step(1'b0, a, 1'b1, 0, '0, '0, "R2 R3 readback");
    idle("R3 idle");
  endtask

  task automatic t_odd();
    step(1'b1, 0, 1'b0, 5, pat(5, 7), pat(5, 8), "R4 odd write");
    idle("R4 settle");
    step(1'b0, 5, 1'b1, 0, '0, '0, "R4 odd read");
    step(1'b0, 4, 1'b1, 0, '0, '0, "R4 even neighbour");
  endtask

  task automatic t_fwd_prev();
    step(1'b1, 0, 1'b0, 10, pat(10, 3), pat(10, 4), "R5 write");
    step(1'b0, 10, 1'b1, 0, '0, '0, "R5 read next edge");
    step(1'b0, 10, 1'b1, 0, '0, '0, "R5 read from array");
    step(1'b1, 0, 1'b0, 13, pat(13, 3), pat(13, 4), "R5 odd write");
    step(1'b0, 12, 1'b1, 0, '0, '0, "R5 partial overlap");
  endtask

  task automatic t_same();
    step(1'b0, 20, 1'b0, 20, pat(20, 5), pat(20, 6), "R6 same edge");
    step(1'b0, 20, 1'b0, 20, pat(20, 7), pat(20, 8), "R6 stacked writes");
    step(1'b0, 21, 1'b0, 21, pat(21, 9), pat(21, 10), "R6 odd same edge");
    step(1'b0, 20, 1'b1, 0, '0, '0, "R6 read back");
  endtask

  task automatic t_nop();
    rd_sel_n = 1'b1; wr_sel_n = 1'b1; wr_addr = AW'(30);
    wr_beat0 = pat(1, 1); wr_beat1 = pat(2, 2);
    @(posedge clk); @(negedge clk);
    check("R7 nop outputs", 1'b0, '0, '0);
    idle("R7 nop");
    step(1'b0, 30, 1'b1, 30, pat(3, 3), pat(4, 4), "R7 unchanged");
    step(1'b0, 30, 1'b1, 0, '0, '0, "R7 unchanged again");
  endtask

  task automatic t_indep();
    step(1'b0, 40, 1'b0, 42, pat(42, 1), pat(42, 2), "R8 concurrent");
    idle("R8 both deselected");
    step(1'b0, 42, 1'b1, 0, '0, '0, "R8 committed");
    step(1'b1, 0, 1'b0, 44, pat(44, 1), pat(44, 2), "R8 read deselected");
    step(1'b0, 44, 1'b1, 0, '0, '0, "R8 write completed");
  endtask

  task automatic t_stream();
    for (int i = 0; i < 8; i++)
      step(1'b0, 2 * i, (i % 2 == 1), 2 * i + 2, pat(i, 20), pat(i, 21), "R9 streaming");
    idle("R9 end");
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = '0;
    t_reset();
    t_fill();
    t_odd();
    t_fwd_prev();
    t_same();
    t_nop();
    t_indep();
    t_stream();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got run still busy expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule